// File: doc/BRIEF.md
# Packed Lane Integer ALU

This block is a datapath for packed integer arithmetic. It takes two 64-bit operands and treats each one as a row of independent lanes: eight bytes, four halfwords or two words. The lane width is picked per operation. For each operation it can add or subtract lanes with wrap-around, signed clamping or unsigned clamping. It can also multiply halfword lanes, keeping the low or the high half of each product. A multiply-add sums adjacent halfword products into word lanes. Compares write whole-lane masks, and the logic operations act on the full 64-bit word.

A caller presents the operands, a 4-bit operation code, a 2-bit lane-width code and a valid strobe. One cycle later the block returns the registered result with a valid flag. An operation code paired with a lane width it does not support returns zero and raises a flag for that one output.

Top module: `simdAlu`

## Requirements
- R1: Operation codes 0 (add) and 3 (subtract) work modulo 2^w in each lane, where the lane width w is 8, 16 or 32 for lane-width codes 0, 1 and 2. A carry or borrow never crosses into a neighbouring lane. Lane i occupies bits [i*w+w-1 : i*w].
- R2: Codes 1 (add) and 4 (subtract) treat lanes as signed. A result above 2^(w-1)-1 is clamped to that value, and a result below -2^(w-1) is clamped to -2^(w-1).
- R3: Codes 2 (add) and 5 (subtract) treat lanes as unsigned. A result above 2^w-1 is clamped to 2^w-1, and a result below zero is clamped to zero.
- R4: Code 6 with lane-width code 1 multiplies four signed 16-bit lane pairs and returns bits 15:0 of each 32-bit product in that lane.
- R5: Codes 7 (signed) and 8 (unsigned) with lane-width code 1 return bits 31:16 of each 32-bit product of the 16-bit lane pair.
- R6: Code 9 with lane-width code 1 forms the four signed 16-bit products and writes the sum of products 2k and 2k+1 into 32-bit lane k, modulo 2^32.
- R7: Code 10 sets a lane to all ones when the two lanes are equal. Code 11 sets a lane to all ones when the first operand's lane is greater as a signed number. Otherwise the lane is all zeros.
- R8: Codes 12 to 15 give the full-width AND, OR, XOR and (NOT first operand) AND second operand. For these codes the lane-width code, including 3, has no effect.
- R9: A valid input produces a valid output on the following cycle. Without a valid input, the output valid flag is low and the result register keeps its previous value.
- R10: Lane-width code 3 with codes 0 to 11, and any lane-width code other than 1 with codes 6 to 9, give a zero result with the illegal-operation flag high for that one output.
- R11: A synchronous reset clears the output valid flag, the illegal-operation flag and the result register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operands and codes are valid this cycle |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| opCode | input | 4 | Operation code |
| laneSel | input | 2 | Lane-width code: 0 byte, 1 halfword, 2 word, 3 unsupported |
| outValid | output | 1 | Result is valid |
| result | output | 64 | Registered result |
| illegalOp | output | 1 | The result came from an unsupported combination |

## Verification
The bench builds the block with its default 64-bit data width. This gives eight, four and two lanes, so a carry, a borrow or a clamp can be placed at every lane boundary and checked against its neighbours. Directed operands cover each clamp edge and the top-bit products. A long run of random operands then covers every operation code against every lane-width code, including the unsupported pairs. Idle cycles between operations show that the result holds its value.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,  OP_ADDSS = 4'd1,  OP_ADDUS = 4'd2,
    OP_SUB   = 4'd3,  OP_SUBSS = 4'd4,  OP_SUBUS = 4'd5,
    OP_MULLO = 4'd6,  OP_MULHS = 4'd7,  OP_MULHU = 4'd8,
    OP_MADD  = 4'd9,  OP_CMPEQ = 4'd10, OP_CMPGT = 4'd11,
    OP_AND   = 4'd12, OP_OR    = 4'd13, OP_XOR   = 4'd14,
    OP_ANDN  = 4'd15
  } simdOp_e;

  typedef enum logic [2:0] {
    K_ARITH, K_CMPEQ, K_CMPGT, K_MULLO, K_MULHS, K_MULHU, K_MADD, K_LOGIC
  } simdKind_e;

  typedef struct packed {
    logic [1:0] laneIdx;
    logic       doSub;
    logic       satSigned;
    logic       satUnsigned;
    simdKind_e  kind;
    logic [1:0] logicSel;
    logic       illegal;
  } simdCtl_t;

  localparam int unsigned NUM_WIDTHS = 3;

endpackage

// File: rtl/simdAluCtrl.sv
module simdAluCtrl
  import simd_alu_pkg::*;
(
  input  logic [3:0] opCode,
  input  logic [1:0] laneSel,
  output simdCtl_t   ctl
);

  always_comb begin
    ctl = '0;
    ctl.kind     = K_ARITH;
    ctl.laneIdx  = (laneSel == 2'd3) ? 2'd0 : laneSel;
    ctl.logicSel = opCode[1:0];
    unique case (simdOp_e'(opCode))
      OP_ADD, OP_ADDSS, OP_ADDUS, OP_SUB, OP_SUBSS, OP_SUBUS: begin
        ctl.kind        = K_ARITH;
        ctl.doSub       = (opCode >= 4'd3);
        ctl.satSigned   = (opCode == 4'd1) || (opCode == 4'd4);
        ctl.satUnsigned = (opCode == 4'd2) || (opCode == 4'd5);
        ctl.illegal     = (laneSel == 2'd3);
      end
      OP_MULLO, OP_MULHS, OP_MULHU, OP_MADD: begin
        ctl.kind    = (opCode == 4'd6) ? K_MULLO :
                      (opCode == 4'd7) ? K_MULHS :
                      (opCode == 4'd8) ? K_MULHU : K_MADD;
        ctl.illegal = (laneSel != 2'd1);
      end
      OP_CMPEQ, OP_CMPGT: begin
        ctl.kind    = (opCode == 4'd10) ? K_CMPEQ : K_CMPGT;
        ctl.illegal = (laneSel == 2'd3);
      end
      default: begin
        ctl.kind    = K_LOGIC;
        ctl.illegal = 1'b0;
      end
    endcase
  end

  // R10: a logic operation is never flagged, whatever the lane-width code
  always_comb begin
    if (opCode[3:2] == 2'b11)
      a_r10_logic_legal: assert (!ctl.illegal);
  end

endmodule

// File: rtl/simdLaneUnit.sv
module simdLaneUnit #(
  parameter int unsigned LANE_W = 8
) (
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  input  logic              doSub,
  input  logic              satSigned,
  input  logic              satUnsigned,
  output logic [LANE_W-1:0] res,
  output logic              isEq,
  output logic              isGt
);

  localparam int unsigned MSB = LANE_W - 1;
  localparam logic [LANE_W-1:0] SMAX = {1'b0, {MSB{1'b1}}};
  localparam logic [LANE_W-1:0] SMIN = {1'b1, {MSB{1'b0}}};

  logic [LANE_W:0]   ext;
  logic [LANE_W-1:0] wrapVal;
  logic              ovSigned;
  logic              ovUnsigned;

  always_comb begin
    ext      = doSub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
    wrapVal  = ext[MSB:0];
    // carry out on add, borrow out on subtract
    ovUnsigned = ext[LANE_W];
    ovSigned   = doSub ? ((a[MSB] != b[MSB]) && (wrapVal[MSB] != a[MSB]))
                       : ((a[MSB] == b[MSB]) && (wrapVal[MSB] != a[MSB]));
    res = wrapVal;
    if (satSigned && ovSigned)
      res = a[MSB] ? SMIN : SMAX;
    else if (satUnsigned && ovUnsigned)
      res = doSub ? '0 : '1;
    isEq = (a == b);
    isGt = ($signed(a) > $signed(b));
  end

endmodule

// File: rtl/simdMulUnit.sv
module simdMulUnit #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] lowHalf,
  output logic [DATA_W-1:0] highSigned,
  output logic [DATA_W-1:0] highUnsigned,
  output logic [DATA_W-1:0] pairSum
);

  localparam int unsigned NUM_H = DATA_W / 16;
  localparam int unsigned NUM_W = DATA_W / 32;

  logic [NUM_H-1:0][31:0] prodS;
  logic [NUM_H-1:0][31:0] prodU;

  for (genvar h = 0; h < NUM_H; h++) begin : g_half
    logic signed [15:0] sa;
    logic signed [15:0] sb;
    assign sa       = a[h*16 +: 16];
    assign sb       = b[h*16 +: 16];
    assign prodS[h] = 32'(sa * sb);
    assign prodU[h] = {16'd0, a[h*16 +: 16]} * {16'd0, b[h*16 +: 16]};
    assign lowHalf[h*16 +: 16]      = prodS[h][15:0];
    assign highSigned[h*16 +: 16]   = prodS[h][31:16];
    assign highUnsigned[h*16 +: 16] = prodU[h][31:16];
  end

  for (genvar w = 0; w < NUM_W; w++) begin : g_pair
    assign pairSum[w*32 +: 32] = prodS[2*w] + prodS[2*w+1];
  end

endmodule

// File: rtl/simdAluPath.sv
module simdAluPath
  import simd_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  simdCtl_t          ctl,
  output logic [DATA_W-1:0] pathRes
);

  logic [NUM_WIDTHS-1:0][DATA_W-1:0] arithRes;
  logic [NUM_WIDTHS-1:0][DATA_W-1:0] eqMask;
  logic [NUM_WIDTHS-1:0][DATA_W-1:0] gtMask;

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
    localparam int unsigned LW = 8 << g;
    localparam int unsigned NL = DATA_W / LW;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      logic laneEq;
      logic laneGt;
      simdLaneUnit #(.LANE_W(LW)) u_lane (
        .a           (opA[l*LW +: LW]),
        .b           (opB[l*LW +: LW]),
        .doSub       (ctl.doSub),
        .satSigned   (ctl.satSigned),
        .satUnsigned (ctl.satUnsigned),
        .res         (arithRes[g][l*LW +: LW]),
        .isEq        (laneEq),
        .isGt        (laneGt)
      );
      assign eqMask[g][l*LW +: LW] = {LW{laneEq}};
      assign gtMask[g][l*LW +: LW] = {LW{laneGt}};
    end
  end

  logic [DATA_W-1:0] mulLow;
  logic [DATA_W-1:0] mulHighS;
  logic [DATA_W-1:0] mulHighU;
  logic [DATA_W-1:0] mulPair;

  simdMulUnit #(.DATA_W(DATA_W)) u_mul (
    .a            (opA),
    .b            (opB),
    .lowHalf      (mulLow),
    .highSigned   (mulHighS),
    .highUnsigned (mulHighU),
    .pairSum      (mulPair)
  );

  logic [DATA_W-1:0] logicRes;
  always_comb begin
    unique case (ctl.logicSel)
      2'd0:    logicRes = opA & opB;
      2'd1:    logicRes = opA | opB;
      2'd2:    logicRes = opA ^ opB;
      default: logicRes = ~opA & opB;
    endcase
  end

  logic [1:0] wIdx;
  assign wIdx = (ctl.laneIdx > 2'd2) ? 2'd0 : ctl.laneIdx;

  always_comb begin
    pathRes = '0;
    if (!ctl.illegal) begin
      unique case (ctl.kind)
        K_ARITH: pathRes = arithRes[wIdx];
        K_CMPEQ: pathRes = eqMask[wIdx];
        K_CMPGT: pathRes = gtMask[wIdx];
        K_MULLO: pathRes = mulLow;
        K_MULHS: pathRes = mulHighS;
        K_MULHU: pathRes = mulHighU;
        K_MADD:  pathRes = mulPair;
        default: pathRes = logicRes;
      endcase
    end
  end

endmodule

// File: rtl/simdAlu.sv
module simdAlu
  import simd_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [3:0]        opCode,
  input  logic [1:0]        laneSel,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              illegalOp
);

  simdCtl_t          ctl;
  logic [DATA_W-1:0] pathRes;

  simdAluCtrl u_ctrl (
    .opCode  (opCode),
    .laneSel (laneSel),
    .ctl     (ctl)
  );

  simdAluPath #(.DATA_W(DATA_W)) u_path (
    .opA     (opA),
    .opB     (opB),
    .ctl     (ctl),
    .pathRes (pathRes)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid  <= 1'b0;
      result    <= '0;
      illegalOp <= 1'b0;
    end else begin
      outValid  <= inValid;
      illegalOp <= inValid && ctl.illegal;
      if (inValid) result <= pathRes;
    end
  end

  // R9: one-cycle latency from a valid input
  a_r9_latency: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  // R9: an idle cycle leaves the result unchanged
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!outValid && $stable(result)));

  // R10: a flagged output is zero and valid
  a_r10_illegal_zero: assert property (@(posedge clk) disable iff (rst)
    illegalOp |-> (outValid && result == '0));

  // R1: byte add wraps lane 1 without a carry from lane 0
  a_r1_lane_carry: assert property (@(posedge clk) disable iff (rst)
    (inValid && opCode == 4'(OP_ADD) && laneSel == 2'd0) |=>
      (result[15:8] == 8'($past(opA[15:8]) + $past(opB[15:8]))));

  // R7: equal operands give an all-ones mask
  a_r7_eq_mask: assert property (@(posedge clk) disable iff (rst)
    (inValid && opCode == 4'(OP_CMPEQ) && laneSel != 2'd3 && opA == opB) |=>
      (result == '1));

  // R8: and-not uses the complement of the first operand
  a_r8_andn: assert property (@(posedge clk) disable iff (rst)
    (inValid && opCode == 4'(OP_ANDN)) |=>
      (result == ($past(~opA) & $past(opB))));

endmodule

// File: tb/sim_simdAlu.sv
module sim_simdAlu;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic [3:0]  opCode = '0;
  logic [1:0]  laneSel = '0;
  logic        outValid;
  logic [63:0] result;
  logic        illegalOp;

  int testCnt = 0;
  int failCnt = 0;
  logic [63:0] lastRes = '0;

  always #(CLK_P/2) clk = ~clk;

  simdAlu u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
    .opCode(opCode), .laneSel(laneSel), .outValid(outValid),
    .result(result), .illegalOp(illegalOp)
  );

  function automatic string reqTag(input int op, input bit ill);
    if (ill) return "R10";
    case (op)
      0, 3:    return "R1";
      1, 4:    return "R2";
      2, 5:    return "R3";
      6:       return "R4";
      7, 8:    return "R5";
      9:       return "R6";
      10, 11:  return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic longint sext(input longint v, input int w);
    if (v >= (longint'(1) << (w-1))) return v - (longint'(1) << w);
    return v;
  endfunction

  function automatic logic [63:0] refModel(input logic [63:0] a, input logic [63:0] b,
                                           input int op, input int ws, output bit ill);
    logic [63:0] r;
    int lw;
    longint full, lo, hi;
    r = '0;
    lw = (ws == 0) ? 8 : (ws == 1) ? 16 : (ws == 2) ? 32 : 0;
    ill = 1'b0;
    if (op >= 12) begin
      case (op)
        12: r = a & b;
        13: r = a | b;
        14: r = a ^ b;
        default: r = ~a & b;
      endcase
      return r;
    end
    if (lw == 0 || (op >= 6 && op <= 9 && lw != 16)) begin
      ill = 1'b1;
      return '0;
    end
    if (op >= 6 && op <= 9) begin
      longint p[4];
      for (int i = 0; i < 4; i++) begin
        longint ua, ub;
        ua = longint'((a >> (i*16)) & 64'hFFFF);
        ub = longint'((b >> (i*16)) & 64'hFFFF);
        p[i] = (op == 8) ? ua * ub : sext(ua, 16) * sext(ub, 16);
        if (op == 6)      r |= (64'(p[i]) & 64'hFFFF) << (i*16);
        else if (op != 9) r |= ((64'(p[i]) >> 16) & 64'hFFFF) << (i*16);
      end
      if (op == 9)
        for (int k = 0; k < 2; k++)
          r |= (64'(p[2*k] + p[2*k+1]) & 64'hFFFF_FFFF) << (k*32);
      return r;
    end
    full = longint'(1) << lw;
    lo = -(full / 2);
    hi = full / 2 - 1;
    for (int i = 0; i < 64 / lw; i++) begin
      longint ua, ub, v;
      ua = longint'((a >> (i*lw)) & 64'(full - 1));
      ub = longint'((b >> (i*lw)) & 64'(full - 1));
      case (op)
        0: v = ua + ub;
        3: v = ua - ub;
        1, 4: begin
          v = (op == 1) ? sext(ua, lw) + sext(ub, lw) : sext(ua, lw) - sext(ub, lw);
          if (v > hi) v = hi;
          if (v < lo) v = lo;
        end
        2, 5: begin
          v = (op == 2) ? ua + ub : ua - ub;
          if (v > full - 1) v = full - 1;
          if (v < 0) v = 0;
        end
        10: v = (ua == ub) ? full - 1 : 0;
        default: v = (sext(ua, lw) > sext(ub, lw)) ? full - 1 : 0;
      endcase
      r |= (64'(v) & 64'(full - 1)) << (i*lw);
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runOp(input logic [63:0] a, input logic [63:0] b, input int op, input int ws);
    logic [63:0] exp;
    bit ill;
    string tag;
    exp = refModel(a, b, op, ws, ill);
    tag = reqTag(op, ill);
    @(negedge clk);
    inValid = 1'b1; opA = a; opB = b; opCode = 4'(op); laneSel = 2'(ws);
    @(posedge clk);
    #1;
    check({tag, " result"}, result, exp);
    check("R9 valid", {63'd0, outValid}, 64'd1);
    check("R10 flag", {63'd0, illegalOp}, {63'd0, ill});
    lastRes = exp;
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0; opA = ~opA; opB = ~opB;
    @(posedge clk);
    #1;
    check("R9 idle valid", {63'd0, outValid}, 64'd0);
    check("R9 idle hold", result, lastRes);
    check("R10 idle flag", {63'd0, illegalOp}, 64'd0);
  endtask

  initial begin
    #(CLK_P * 100000);
    failCnt++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11: reset state
    check("R11 valid", {63'd0, outValid}, 64'd0);
    check("R11 result", result, 64'd0);
    check("R11 flag", {63'd0, illegalOp}, 64'd0);
    @(negedge clk);
    rst = 1'b0;

    // R1: carries and borrows stay inside lanes
    runOp(64'h00FF_00FF_FFFF_FFFF, 64'h0001_0001_0000_0001, 0, 0);
    runOp(64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 0, 1);
    runOp(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 0, 2);
    runOp(64'h0100_0000_0000_0000, 64'h0001_0000_0000_0001, 3, 0);
    idle();
    // R2: signed clamps
    runOp(64'h7F80_7F80_0102_0304, 64'h0101_80FF_0101_0101, 1, 0);
    runOp(64'h8000_7FFF_0005_FFFF, 64'h0001_FFFF_0003_0001, 4, 1);
    runOp(64'h7FFF_FFFF_8000_0000, 64'h0000_0001_0000_0001, 1, 2);
    // R3: unsigned clamps
    runOp(64'hFF00_FE10_0000_0102, 64'h0100_0505_0001_0101, 2, 0);
    runOp(64'h0000_0005_FFFF_0003, 64'h0001_0003_0001_0005, 5, 1);
    // R4, R5, R6: halfword multiplies
    runOp(64'hFFFF_8000_7FFF_0003, 64'hFFFF_8000_7FFF_FFFE, 6, 1);
    runOp(64'hFFFF_8000_7FFF_0003, 64'hFFFF_8000_7FFF_FFFE, 7, 1);
    runOp(64'hFFFF_8000_7FFF_0003, 64'hFFFF_8000_7FFF_FFFE, 8, 1);
    runOp(64'h8000_8000_0002_FFFF, 64'h8000_8000_0003_0004, 9, 1);
    // R7: masks
    runOp(64'h1122_3344_5566_7780, 64'h1122_0044_5500_777F, 10, 0);
    runOp(64'h8000_0001_7FFF_0000, 64'h7FFF_0000_8000_0000, 11, 1);
    // R8: width code ignored, including 3
    runOp(64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_1111, 15, 3);
    runOp(64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_1111, 14, 2);
    // R10: unsupported pairs
    runOp(64'h1234, 64'h5678, 6, 0);
    runOp(64'h1234, 64'h5678, 0, 3);
    idle();
    // random coverage of all codes and widths
    for (int n = 0; n < 600; n++) begin
      runOp({$urandom, $urandom}, {$urandom, $urandom}, int'($urandom % 16), int'($urandom % 4));
      if (n % 7 == 0) idle();
    end
    // R11: reset mid-stream clears outputs
    @(negedge clk);
    inValid = 1'b1; rst = 1'b1;
    @(posedge clk);
    #1;
    check("R11 rerun valid", {63'd0, outValid}, 64'd0);
    check("R11 rerun result", result, 64'd0);
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule